// File: doc/BRIEF.md
# Adjacent-Subband Combining Network

This block sits at the end of a channelizer. Nine time-aligned, signed subband streams arrive in parallel, numbered 0 to 8 from the low edge of the spectrum to the high edge. The block passes every band through unchanged. From the same sample it also forms wider channels by adding up to four neighbouring bands. Non-uniform channel plans can then be carved out of a uniform grid of subbands.

The combining runs in two stages. The first stage uses four 2-input multiplexers, one for each mirrored pair of bands (0/8, 1/7, 2/6, 3/5). A pair mirrored about the centre band is never needed in the same sum. Two edge sums and two inner sums are built from the multiplexer outputs. One select bit decides whether the low-spectrum or the high-spectrum version of each sum appears on the "a" output, and the "b" output always carries the other version. The second stage selects among sums of the first-stage results to produce a centre output and two wide outputs. A fixed three-band sum around the centre band completes the eight combined outputs.

When the upstream filter paths run with unlike decimation settings, sums across band boundaries are meaningless. In that case the combining enable is held low. All combined outputs then read zero and only the nine individual bands carry data. All outputs are registered, so results appear one clock after a valid input.

Top module: `subband_combiner`

## Requirements
- R1: Each input band k (bits k*SAMPLE_W +: SAMPLE_W of `band_i`) appears unchanged on the same slice of `band_o` one cycle after a valid input, whatever the values of `comb_en` and `band_sel`.
- R2: With `band_sel[0]`=0, `edge_a_o` = b0+b1 and `edge_b_o` = b7+b8. With `band_sel[0]`=1 the two sums are swapped.
- R3: With `band_sel[0]`=0, `inner_a_o` = b2+b3 and `inner_b_o` = b5+b6. With `band_sel[0]`=1 the two sums are swapped.
- R4: `center_o` follows `band_sel[2:1]`: 0 gives b4, 1 gives `inner_a`, 2 gives `inner_a`+b4, 3 gives b4+b3 (when `band_sel[0]`=0) or b4+b5 (when `band_sel[0]`=1).
- R5: `wide_a_o` follows `band_sel[4:3]`: 0 gives `edge_a`+b2 (when `band_sel[0]`=0) or `edge_a`+b6 (when `band_sel[0]`=1), 1 gives `edge_a`+`inner_a`, 2 gives `edge_a`, 3 gives `inner_b`+b4.
- R6: `wide_b_o` follows `band_sel[5]`: 0 gives `edge_b`+`inner_b`, 1 gives `edge_b`+b6 (when `band_sel[0]`=0) or `edge_b`+b2 (when `band_sel[0]`=1).
- R7: `middle_o` is always b3+b4+b5.
- R8: When `comb_en` is low at a valid input, all eight combined outputs are zero one cycle later.
- R9: Combined outputs are SAMPLE_W+2 bits wide and exact for any input, including four full-scale negative or positive bands.
- R10: `out_valid` is `in_valid` delayed by one cycle. While `in_valid` is low, every data output holds its last value.
- R11: While reset is high, `out_valid`, `band_o` and every combined output are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Marks a valid set of nine band samples |
| comb_en | input | 1 | Enables the adjacent-band sums; low forces them to zero |
| band_sel | input | 6 | Combining select: bit 0 mirror, bits 2:1 centre, bits 4:3 wide a, bit 5 wide b |
| band_i | input | 9*SAMPLE_W | Nine signed band samples, band k at bits k*SAMPLE_W +: SAMPLE_W |
| out_valid | output | 1 | Registered valid |
| band_o | output | 9*SAMPLE_W | Registered copy of the nine bands |
| edge_a_o | output | SAMPLE_W+2 | Selected edge two-band sum |
| edge_b_o | output | SAMPLE_W+2 | Complementary edge two-band sum |
| inner_a_o | output | SAMPLE_W+2 | Selected inner two-band sum |
| inner_b_o | output | SAMPLE_W+2 | Complementary inner two-band sum |
| center_o | output | SAMPLE_W+2 | Centre output chosen by bits 2:1 |
| wide_a_o | output | SAMPLE_W+2 | Wide output chosen by bits 4:3 |
| wide_b_o | output | SAMPLE_W+2 | Wide output chosen by bit 5 |
| middle_o | output | SAMPLE_W+2 | Fixed sum of bands 3, 4 and 5 |

## Verification
The bench builds the block with its default SAMPLE_W of 16. Each band can then be driven to both full-scale extremes, -32768 and 32767. The four-band sums therefore reach -131072 and 131068, which test the two guard bits of the 18-bit outputs directly. Distinct band values are used in each test, so a wrong pair, a missing mirror swap or a wrong second-stage choice shows up as a different number on the affected output.

// File: rtl/subband_pkg.sv
package subband_pkg;

    localparam int NBANDS = 9;
    localparam int NPAIRS = 4;
    localparam int SEL_W  = 6;
    localparam int GROW   = 2;
    localparam int NCOMB  = 8;

    typedef enum logic [1:0] {
        CTR_MID    = 2'd0,
        CTR_PAIR   = 2'd1,
        CTR_TRIPLE = 2'd2,
        CTR_DUO    = 2'd3
    } center_e;

    typedef enum logic [1:0] {
        WA_EDGE_NEAR  = 2'd0,
        WA_EDGE_INNER = 2'd1,
        WA_EDGE_ONLY  = 2'd2,
        WA_INNER_MID  = 2'd3
    } wide_a_e;

    typedef enum logic {
        WB_EDGE_INNER = 1'b0,
        WB_EDGE_NEAR  = 1'b1
    } wide_b_e;

    typedef struct packed {
        wide_b_e wb;
        wide_a_e wa;
        center_e ctr;
        logic    mirror;
    } sel_t;

    typedef enum int {
        OUT_EDGE_A  = 0,
        OUT_EDGE_B  = 1,
        OUT_INNER_A = 2,
        OUT_INNER_B = 3,
        OUT_CENTER  = 4,
        OUT_WIDE_A  = 5,
        OUT_WIDE_B  = 6,
        OUT_MIDDLE  = 7
    } comb_idx_e;

    function automatic sel_t decode_sel(input logic [SEL_W-1:0] s);
        sel_t d;
        d.mirror = s[0];
        d.ctr    = center_e'(s[2:1]);
        d.wa     = wide_a_e'(s[4:3]);
        d.wb     = wide_b_e'(s[5]);
        return d;
    endfunction

endpackage

// File: rtl/sb_pair_stage.sv
module sb_pair_stage
    import subband_pkg::*;
#(
    parameter int IN_W = 16,
    parameter int SUM_W = IN_W + GROW
) (
    input  logic [NBANDS*IN_W-1:0] bands_i,
    input  logic                   mirror_i,
    output logic [SUM_W-1:0]       edge_a_o,
    output logic [SUM_W-1:0]       edge_b_o,
    output logic [SUM_W-1:0]       inner_a_o,
    output logic [SUM_W-1:0]       inner_b_o,
    output logic [SUM_W-1:0]       near_o,
    output logic [SUM_W-1:0]       far_o,
    output logic [SUM_W-1:0]       side_o,
    output logic [SUM_W-1:0]       mid_o,
    output logic [SUM_W-1:0]       middle_o
);

    localparam int EXT = SUM_W - IN_W;

    logic [SUM_W-1:0] ext [NBANDS];
    logic [SUM_W-1:0] lo_pick [NPAIRS];
    logic [SUM_W-1:0] hi_pick [NPAIRS];

    // sign extension of every band to the sum width
    for (genvar g = 0; g < NBANDS; g++) begin : g_ext
        assign ext[g] = {{EXT{bands_i[g*IN_W+IN_W-1]}}, bands_i[g*IN_W +: IN_W]};
    end

    // one 2-input mux per mirrored pair (p, 8-p); mirror swaps the roles
    for (genvar p = 0; p < NPAIRS; p++) begin : g_pair
        assign lo_pick[p] = mirror_i ? ext[NBANDS-1-p] : ext[p];
        assign hi_pick[p] = mirror_i ? ext[p] : ext[NBANDS-1-p];
    end

    assign edge_a_o  = lo_pick[0] + lo_pick[1];
    assign edge_b_o  = hi_pick[0] + hi_pick[1];
    assign inner_a_o = lo_pick[2] + lo_pick[3];
    assign inner_b_o = hi_pick[2] + hi_pick[3];
    assign near_o    = lo_pick[2];
    assign far_o     = hi_pick[2];
    assign side_o    = lo_pick[3];
    assign mid_o     = ext[NPAIRS];
    assign middle_o  = ext[NPAIRS-1] + ext[NPAIRS] + ext[NPAIRS+1];

endmodule

// File: rtl/sb_wide_stage.sv
module sb_wide_stage
    import subband_pkg::*;
#(
    parameter int SUM_W = 18
) (
    input  sel_t             sel_i,
    input  logic [SUM_W-1:0] edge_a_i,
    input  logic [SUM_W-1:0] edge_b_i,
    input  logic [SUM_W-1:0] inner_a_i,
    input  logic [SUM_W-1:0] inner_b_i,
    input  logic [SUM_W-1:0] near_i,
    input  logic [SUM_W-1:0] far_i,
    input  logic [SUM_W-1:0] side_i,
    input  logic [SUM_W-1:0] mid_i,
    output logic [SUM_W-1:0] center_o,
    output logic [SUM_W-1:0] wide_a_o,
    output logic [SUM_W-1:0] wide_b_o
);

    always_comb begin
        unique case (sel_i.ctr)
            CTR_MID:    center_o = mid_i;
            CTR_PAIR:   center_o = inner_a_i;
            CTR_TRIPLE: center_o = inner_a_i + mid_i;
            CTR_DUO:    center_o = mid_i + side_i;
            default:    center_o = '0;
        endcase
    end

    always_comb begin
        unique case (sel_i.wa)
            WA_EDGE_NEAR:  wide_a_o = edge_a_i + near_i;
            WA_EDGE_INNER: wide_a_o = edge_a_i + inner_a_i;
            WA_EDGE_ONLY:  wide_a_o = edge_a_i;
            WA_INNER_MID:  wide_a_o = inner_b_i + mid_i;
            default:       wide_a_o = '0;
        endcase
    end

    always_comb begin
        unique case (sel_i.wb)
            WB_EDGE_INNER: wide_b_o = edge_b_i + inner_b_i;
            WB_EDGE_NEAR:  wide_b_o = edge_b_i + far_i;
            default:       wide_b_o = '0;
        endcase
    end

endmodule

// File: rtl/sb_out_reg.sv
module sb_out_reg
    import subband_pkg::*;
#(
    parameter int BAND_W = 144,
    parameter int SUM_W  = 18
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        load_i,
    input  logic [BAND_W-1:0]           band_d,
    input  logic [NCOMB-1:0][SUM_W-1:0] comb_d,
    output logic                        valid_q,
    output logic [BAND_W-1:0]           band_q,
    output logic [NCOMB-1:0][SUM_W-1:0] comb_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            band_q  <= '0;
            comb_q  <= '0;
        end else begin
            valid_q <= load_i;
            if (load_i) begin
                band_q <= band_d;
                comb_q <= comb_d;
            end
        end
    end

endmodule

// File: rtl/subband_combiner.sv
module subband_combiner
    import subband_pkg::*;
#(
    parameter int SAMPLE_W = 16
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         in_valid,
    input  logic                         comb_en,
    input  logic [SEL_W-1:0]             band_sel,
    input  logic [NBANDS*SAMPLE_W-1:0]   band_i,
    output logic                         out_valid,
    output logic [NBANDS*SAMPLE_W-1:0]   band_o,
    output logic [SAMPLE_W+GROW-1:0]     edge_a_o,
    output logic [SAMPLE_W+GROW-1:0]     edge_b_o,
    output logic [SAMPLE_W+GROW-1:0]     inner_a_o,
    output logic [SAMPLE_W+GROW-1:0]     inner_b_o,
    output logic [SAMPLE_W+GROW-1:0]     center_o,
    output logic [SAMPLE_W+GROW-1:0]     wide_a_o,
    output logic [SAMPLE_W+GROW-1:0]     wide_b_o,
    output logic [SAMPLE_W+GROW-1:0]     middle_o
);

    localparam int SUM_W  = SAMPLE_W + GROW;
    localparam int BAND_W = NBANDS * SAMPLE_W;

    sel_t sel;
    assign sel = decode_sel(band_sel);

    logic [NCOMB-1:0][SUM_W-1:0] comb_raw;
    logic [NCOMB-1:0][SUM_W-1:0] comb_gated;
    logic [NCOMB-1:0][SUM_W-1:0] comb_q;
    logic [SUM_W-1:0] near_w, far_w, side_w, mid_w;

    sb_pair_stage #(.IN_W(SAMPLE_W), .SUM_W(SUM_W)) u_pair (
        .bands_i   (band_i),
        .mirror_i  (sel.mirror),
        .edge_a_o  (comb_raw[OUT_EDGE_A]),
        .edge_b_o  (comb_raw[OUT_EDGE_B]),
        .inner_a_o (comb_raw[OUT_INNER_A]),
        .inner_b_o (comb_raw[OUT_INNER_B]),
        .near_o    (near_w),
        .far_o     (far_w),
        .side_o    (side_w),
        .mid_o     (mid_w),
        .middle_o  (comb_raw[OUT_MIDDLE])
    );

    sb_wide_stage #(.SUM_W(SUM_W)) u_wide (
        .sel_i     (sel),
        .edge_a_i  (comb_raw[OUT_EDGE_A]),
        .edge_b_i  (comb_raw[OUT_EDGE_B]),
        .inner_a_i (comb_raw[OUT_INNER_A]),
        .inner_b_i (comb_raw[OUT_INNER_B]),
        .near_i    (near_w),
        .far_i     (far_w),
        .side_i    (side_w),
        .mid_i     (mid_w),
        .center_o  (comb_raw[OUT_CENTER]),
        .wide_a_o  (comb_raw[OUT_WIDE_A]),
        .wide_b_o  (comb_raw[OUT_WIDE_B])
    );

    // combining disabled: every combined output is zero (R8)
    for (genvar i = 0; i < NCOMB; i++) begin : g_gate
        assign comb_gated[i] = comb_en ? comb_raw[i] : '0;
    end

    sb_out_reg #(.BAND_W(BAND_W), .SUM_W(SUM_W)) u_reg (
        .clk     (clk),
        .rst     (rst),
        .load_i  (in_valid),
        .band_d  (band_i),
        .comb_d  (comb_gated),
        .valid_q (out_valid),
        .band_q  (band_o),
        .comb_q  (comb_q)
    );

    assign edge_a_o  = comb_q[OUT_EDGE_A];
    assign edge_b_o  = comb_q[OUT_EDGE_B];
    assign inner_a_o = comb_q[OUT_INNER_A];
    assign inner_b_o = comb_q[OUT_INNER_B];
    assign center_o  = comb_q[OUT_CENTER];
    assign wide_a_o  = comb_q[OUT_WIDE_A];
    assign wide_b_o  = comb_q[OUT_WIDE_B];
    assign middle_o  = comb_q[OUT_MIDDLE];

endmodule

// File: rtl/subband_combiner_chk.sv
module subband_combiner_chk
    import subband_pkg::*;
#(
    parameter int SAMPLE_W = 16
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       in_valid,
    input logic                       comb_en,
    input logic [NBANDS*SAMPLE_W-1:0] band_i,
    input logic                       out_valid,
    input logic [NBANDS*SAMPLE_W-1:0] band_o,
    input logic [SAMPLE_W+GROW-1:0]   edge_a_o,
    input logic [SAMPLE_W+GROW-1:0]   edge_b_o,
    input logic [SAMPLE_W+GROW-1:0]   inner_a_o,
    input logic [SAMPLE_W+GROW-1:0]   inner_b_o,
    input logic [SAMPLE_W+GROW-1:0]   center_o,
    input logic [SAMPLE_W+GROW-1:0]   wide_a_o,
    input logic [SAMPLE_W+GROW-1:0]   wide_b_o,
    input logic [SAMPLE_W+GROW-1:0]   middle_o
);

    localparam int SUM_W = SAMPLE_W + GROW;
    localparam int EXT   = SUM_W - SAMPLE_W;

    logic armed;
    logic rst_q;
    always_ff @(posedge clk) begin
        rst_q <= rst;
        if (rst) armed <= 1'b0;
        else     armed <= 1'b1;
    end

    logic [SUM_W-1:0] bx [NBANDS];
    for (genvar g = 0; g < NBANDS; g++) begin : g_bx
        assign bx[g] = {{EXT{band_i[g*SAMPLE_W+SAMPLE_W-1]}}, band_i[g*SAMPLE_W +: SAMPLE_W]};
    end

    logic [SUM_W-1:0] edge_total, inner_total, edge_pair_out, inner_pair_out;
    logic             edge_nonneg;
    assign edge_total     = bx[0] + bx[1] + bx[7] + bx[8];
    assign inner_total    = bx[2] + bx[3] + bx[5] + bx[6];
    assign edge_pair_out  = edge_a_o + edge_b_o;
    assign inner_pair_out = inner_a_o + inner_b_o;
    assign edge_nonneg    = !bx[0][SUM_W-1] && !bx[1][SUM_W-1] &&
                            !bx[7][SUM_W-1] && !bx[8][SUM_W-1];

    logic all_comb_zero;
    assign all_comb_zero = (edge_a_o == '0) && (edge_b_o == '0) && (inner_a_o == '0) &&
                           (inner_b_o == '0) && (center_o == '0) && (wide_a_o == '0) &&
                           (wide_b_o == '0) && (middle_o == '0);

    assert_pass_R1: assert property (@(posedge clk) disable iff (rst)
        armed && $past(in_valid) |-> band_o == $past(band_i));

    assert_edge_pair_R2: assert property (@(posedge clk) disable iff (rst)
        armed && $past(in_valid && comb_en) |-> edge_pair_out == $past(edge_total));

    assert_inner_pair_R3: assert property (@(posedge clk) disable iff (rst)
        armed && $past(in_valid && comb_en) |-> inner_pair_out == $past(inner_total));

    assert_gate_R8: assert property (@(posedge clk) disable iff (rst)
        armed && $past(in_valid && !comb_en) |-> all_comb_zero);

    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
        armed && $past(in_valid && comb_en && edge_nonneg) |-> !edge_a_o[SUM_W-1] && !edge_b_o[SUM_W-1]);

    assert_valid_delay_R10: assert property (@(posedge clk) disable iff (rst)
        armed |-> out_valid == $past(in_valid));

    assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
        armed && !$past(in_valid) |-> $stable(band_o) && $stable(wide_a_o) && $stable(center_o));

    assert_reset_R11: assert property (@(posedge clk)
        rst_q |-> !out_valid && band_o == '0 && all_comb_zero);

endmodule

bind subband_combiner subband_combiner_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .comb_en   (comb_en),
    .band_i    (band_i),
    .out_valid (out_valid),
    .band_o    (band_o),
    .edge_a_o  (edge_a_o),
    .edge_b_o  (edge_b_o),
    .inner_a_o (inner_a_o),
    .inner_b_o (inner_b_o),
    .center_o  (center_o),
    .wide_a_o  (wide_a_o),
    .wide_b_o  (wide_b_o),
    .middle_o  (middle_o)
);

// File: tb/subband_combiner_bench.sv
module subband_combiner_bench;

    localparam int W  = 16;
    localparam int SW = W + 2;
    localparam int NB = 9;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic comb_en = 1'b0;
    logic [5:0] band_sel = '0;
    logic [NB*W-1:0] band_i = '0;
    logic out_valid;
    logic [NB*W-1:0] band_o;
    logic [SW-1:0] edge_a_o, edge_b_o, inner_a_o, inner_b_o;
    logic [SW-1:0] center_o, wide_a_o, wide_b_o, middle_o;

    always #2.5 clk = ~clk;

    subband_combiner #(.SAMPLE_W(W)) u_subband_combiner (
        .clk(clk), .rst(rst), .in_valid(in_valid), .comb_en(comb_en),
        .band_sel(band_sel), .band_i(band_i), .out_valid(out_valid), .band_o(band_o),
        .edge_a_o(edge_a_o), .edge_b_o(edge_b_o), .inner_a_o(inner_a_o),
        .inner_b_o(inner_b_o), .center_o(center_o), .wide_a_o(wide_a_o),
        .wide_b_o(wide_b_o), .middle_o(middle_o)
    );

    int n_checks = 0;
    int n_fail   = 0;
    int cur_b [NB];
    int exp_c [8];

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    // expected outputs written from the requirement text
    task automatic model(input logic [5:0] s, input logic en);
        int b[NB];
        logic m;
        int lo_e, hi_e, lo_i, hi_i;
        b = cur_b;
        m = s[0];
        lo_e = b[0] + b[1]; hi_e = b[7] + b[8];
        lo_i = b[2] + b[3]; hi_i = b[5] + b[6];
        exp_c[0] = m ? hi_e : lo_e;                        // R2
        exp_c[1] = m ? lo_e : hi_e;
        exp_c[2] = m ? hi_i : lo_i;                        // R3
        exp_c[3] = m ? lo_i : hi_i;
        case (s[2:1])                                      // R4
            2'd0: exp_c[4] = b[4];
            2'd1: exp_c[4] = exp_c[2];
            2'd2: exp_c[4] = exp_c[2] + b[4];
            default: exp_c[4] = b[4] + (m ? b[5] : b[3]);
        endcase
        case (s[4:3])                                      // R5
            2'd0: exp_c[5] = exp_c[0] + (m ? b[6] : b[2]);
            2'd1: exp_c[5] = exp_c[0] + exp_c[2];
            2'd2: exp_c[5] = exp_c[0];
            default: exp_c[5] = exp_c[3] + b[4];
        endcase
        exp_c[6] = s[5] ? exp_c[1] + (m ? b[2] : b[6]) : exp_c[1] + exp_c[3];  // R6
        exp_c[7] = b[3] + b[4] + b[5];                     // R7
        if (!en) for (int i = 0; i < 8; i++) exp_c[i] = 0; // R8
    endtask

    function automatic int sx(input logic [SW-1:0] v);
        return int'($signed(v));
    endfunction

    task automatic check_outputs(input string tag);
        for (int k = 0; k < NB; k++)
            check({tag, " R1"}, $sformatf("band_o[%0d]", k),
                  int'($signed(band_o[k*W +: W])), cur_b[k]);
        check({tag, " R2"}, "edge_a",  sx(edge_a_o),  exp_c[0]);
        check({tag, " R2"}, "edge_b",  sx(edge_b_o),  exp_c[1]);
        check({tag, " R3"}, "inner_a", sx(inner_a_o), exp_c[2]);
        check({tag, " R3"}, "inner_b", sx(inner_b_o), exp_c[3]);
        check({tag, " R4"}, "center",  sx(center_o),  exp_c[4]);
        check({tag, " R5"}, "wide_a",  sx(wide_a_o),  exp_c[5]);
        check({tag, " R6"}, "wide_b",  sx(wide_b_o),  exp_c[6]);
        check({tag, " R7"}, "middle",  sx(middle_o),  exp_c[7]);
    endtask

    task automatic apply(input string tag, input logic [5:0] s, input logic en);
        @(negedge clk);
        for (int k = 0; k < NB; k++) band_i[k*W +: W] = cur_b[k][W-1:0];
        band_sel = s;
        comb_en  = en;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        model(s, en);
        check({tag, " R10"}, "out_valid", int'(out_valid), 1);
        check_outputs(tag);
    endtask

    task automatic set_ramp(input int base, input int step);
        for (int k = 0; k < NB; k++) cur_b[k] = base + k * step;
    endtask

    task automatic t_reset();
        check("R11", "out_valid", int'(out_valid), 0);
        check("R11", "band_o", int'(band_o != '0), 0);
        check("R11", "wide_a", sx(wide_a_o), 0);
        check("R11", "middle", sx(middle_o), 0);
    endtask

    task automatic t_pass();
        set_ramp(11, 101);  apply("pass", 6'b000000, 1'b1);
        set_ramp(-900, 37); apply("pass", 6'b101011, 1'b1);
        for (int k = 0; k < NB; k++) cur_b[k] = (k % 2) ? -(k * 1000 + 3) : k * 777;
        apply("pass", 6'b010101, 1'b1);
    endtask

    task automatic t_mirror();
        set_ramp(1, 10);
        apply("mirror0 R2 R3", 6'b000000, 1'b1);
        apply("mirror1 R2 R3", 6'b000001, 1'b1);
    endtask

    task automatic t_center();
        set_ramp(-50, 13);
        for (int c = 0; c < 4; c++)
            for (int m = 0; m < 2; m++)
                apply("center R4", {3'b000, c[1:0], m[0]}, 1'b1);
    endtask

    task automatic t_wide_a();
        set_ramp(200, -31);
        for (int c = 0; c < 4; c++)
            for (int m = 0; m < 2; m++)
                apply("wide_a R5", {1'b0, c[1:0], 2'b00, m[0]}, 1'b1);
    endtask

    task automatic t_wide_b();
        set_ramp(7, 55);
        for (int c = 0; c < 2; c++)
            for (int m = 0; m < 2; m++)
                apply("wide_b R6", {c[0], 4'b0000, m[0]}, 1'b1);
    endtask

    task automatic t_middle();
        cur_b = '{1, 2, 3, -400, 5000, 123, 7, 8, 9};
        apply("middle R7", 6'b111111, 1'b1);
    endtask

    task automatic t_gate();
        set_ramp(300, 17);
        apply("gate R8", 6'b001011, 1'b0);
        apply("gate R8 mirror", 6'b110101, 1'b0);
    endtask

    task automatic t_extremes();
        for (int k = 0; k < NB; k++) cur_b[k] = -32768;
        apply("neg full scale R9", 6'b001000, 1'b1);
        check("R9", "wide_a four-band min", sx(wide_a_o), -131072);
        for (int k = 0; k < NB; k++) cur_b[k] = 32767;
        apply("pos full scale R9", 6'b001001, 1'b1);
        check("R9", "wide_a four-band max", sx(wide_a_o), 131068);
    endtask

    task automatic t_hold();
        set_ramp(-77, 19);
        apply("hold R10", 6'b010010, 1'b1);
        // new data without valid must not reach the outputs
        @(negedge clk);
        band_i   = {NB{16'h1234}};
        band_sel = 6'b101101;
        @(negedge clk);
        @(negedge clk);
        check("R10", "out_valid low", int'(out_valid), 0);
        check_outputs("hold R10");
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        repeat (4) @(negedge clk);
        t_reset();
        rst = 1'b0;
        t_pass();
        t_mirror();
        t_center();
        t_wide_a();
        t_wide_b();
        t_middle();
        t_gate();
        t_extremes();
        t_hold();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule